// File: doc/BRIEF.md
# Self-Starting Watchdog Timer

This block is a watchdog counter that is already running when system reset is released; software does nothing to start it. It counts ticks from one of three clock-enable inputs (main, internal oscillator, sub) and, when the count reaches the selected threshold, it emits a one-cycle request. Depending on a mode bit, that request goes to the reset generator or to the non-maskable interrupt input of the interrupt controller.

Software reaches the block through a small byte-wide write port with two targets. One is a configuration register that accepts a single write after reset. That write picks the clock source, the threshold, the overflow action and a permanent stop. Software should make this write even when it keeps the defaults, because it locks the register. The other target is a restart register: writing the key value zeroes the count, and any other value is treated as a fault. Both kinds of misuse, a second configuration write or a wrong key, raise the reset request at once.

Top module: `wdt_autostart`

## Requirements
- R1: With no write after reset, the counter advances on the internal-oscillator enable alone, and the 2^(MIN_EXP+7)-th such tick produces a reset request.
- R2: `rst_req` and `nmi_req` are outputs registered on `clk`, each high for exactly one cycle per event, and never high in the same cycle.
- R3: Configuration bits [2:0] (reset value 7) pick the threshold: an overflow happens on the 2^(MIN_EXP+field)-th selected tick.
- R4: Configuration bits [4:3] (reset value 0) pick the tick source: 0 or 3 selects `ce_iosc`, 1 selects `ce_main`, 2 selects `ce_sub`. The enables that are not selected have no effect on the count.
- R5: Configuration bit 5 (reset value 0) picks the action. 0 means an overflow pulses `rst_req`, and 1 means it pulses `nmi_req` instead. In both cases the count restarts from zero, so the next overflow follows after another full interval.
- R6: Only the first configuration write after reset (`wr_sel`=0) takes effect. Every later one changes nothing and pulses `rst_req` in the cycle after the write.
- R7: A write of 8'hAC to the restart register (`wr_sel`=1) zeroes the count, so the next overflow comes a full interval after that write.
- R8: A write of any other value to the restart register pulses `rst_req` in the cycle after the write.
- R9: Configuration bit 6 (reset value 0) set to 1 stops the counter. No overflow occurs after that until the next system reset, including after a restart-key write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| ce_main | input | 1 | Main-clock tick enable |
| ce_iosc | input | 1 | Internal-oscillator tick enable |
| ce_sub | input | 1 | Subclock tick enable |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 configuration, 1 restart |
| wr_data | input | 8 | Write data |
| rst_req | output | 1 | One-cycle reset request |
| nmi_req | output | 1 | One-cycle non-maskable interrupt request |

## Verification
With a reduced threshold exponent, the bench sweeps all eight threshold codes in both action modes and measures the exact tick count to the first pulse. This separates off-by-one thresholds from a wrong output choice. Each source code is tried while the selected enable toggles irregularly and the other enables are held high, so a count taken from the wrong enable arrives early. Separate sequences show that the second configuration write is ignored yet faulted, that a key write restarts a partly elapsed interval while a bad key faults, and that a stopped counter stays silent even after a restart key.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [7:0] RESTART_KEY = 8'hAC;

  typedef enum logic [1:0] {
    SRC_IOSC  = 2'd0,
    SRC_MAIN  = 2'd1,
    SRC_SUB   = 2'd2,
    SRC_IOSC2 = 2'd3
  } wdt_src_e;

  // Field order is the byte layout of the configuration register, MSB first.
  typedef struct packed {
    logic     halt;
    logic     nmi_mode;
    wdt_src_e src;
    logic [2:0] ovsel;
  } wdt_cfg_t;

  localparam wdt_cfg_t CFG_DEFAULT = '{halt: 1'b0, nmi_mode: 1'b0,
                                       src: SRC_IOSC, ovsel: 3'd7};
endpackage

// File: rtl/wdt_cfg_reg.sv
module wdt_cfg_reg
  import wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_cfg,
  input  logic [7:0] wr_data,
  output wdt_cfg_t   cfg,
  output logic       cfg_fault
);
  wdt_cfg_t cfg_q;
  logic     locked;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= CFG_DEFAULT;
      locked <= 1'b0;
    end else if (wr_cfg && !locked) begin
      cfg_q  <= wdt_cfg_t'(wr_data[6:0]);
      locked <= 1'b1;
    end
  end

  assign cfg       = cfg_q;
  assign cfg_fault = wr_cfg && locked;

  // R6: once locked, a further write leaves the configuration untouched
  p_cfg_once_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_cfg && locked) |=> $stable(cfg_q));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int MIN_EXP = 12,
  localparam int CNT_W  = MIN_EXP + 8
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     ce_main,
  input  logic     ce_iosc,
  input  logic     ce_sub,
  input  wdt_cfg_t cfg,
  input  logic     restart,
  output logic     ovf
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim_m1;
  logic             tick;
  logic             run;

  always_comb begin
    unique case (cfg.src)
      SRC_MAIN: tick = ce_main;
      SRC_SUB:  tick = ce_sub;
      default:  tick = ce_iosc;
    endcase
  end

  assign lim_m1 = (CNT_W'(1) << (MIN_EXP + int'(cfg.ovsel))) - CNT_W'(1);
  assign run    = !cfg.halt;
  assign ovf    = run && tick && !restart && (cnt >= lim_m1);

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (restart)     cnt <= '0;
    else if (ovf)         cnt <= '0;
    else if (run && tick) cnt <= cnt + CNT_W'(1);
  end

  // R7: the restart key zeroes the count
  p_restart_zero_r7: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt == '0));
  // R5: after an overflow the count begins again from zero
  p_ovf_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    ovf |=> (cnt == '0));
  // R9: a halted counter holds its value
  p_halt_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (cfg.halt && !restart) |=> $stable(cnt));
endmodule

// File: rtl/wdt_req_gen.sv
module wdt_req_gen (
  input  logic clk,
  input  logic rst,
  input  logic ovf,
  input  logic nmi_mode,
  input  logic cfg_fault,
  input  logic key_fault,
  output logic rst_req,
  output logic nmi_req
);
  logic fault;
  logic rst_d;
  logic nmi_d;

  assign fault = cfg_fault || key_fault;
  assign rst_d = fault || (ovf && !nmi_mode);
  assign nmi_d = ovf && nmi_mode && !fault;

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_req <= 1'b0;
      nmi_req <= 1'b0;
    end else begin
      rst_req <= rst_d;
      nmi_req <= nmi_d;
    end
  end

  // R2: the two requests never coincide
  p_req_excl_r2: assert property (@(posedge clk) disable iff (rst)
    !(rst_req && nmi_req));
  // R8: a wrong restart key is answered by a reset request
  p_bad_key_r8: assert property (@(posedge clk) disable iff (rst)
    key_fault |=> rst_req);
  // R5: an overflow in interrupt mode raises only the interrupt request
  p_nmi_only_r5: assert property (@(posedge clk) disable iff (rst)
    (ovf && nmi_mode && !cfg_fault && !key_fault) |=> (nmi_req && !rst_req));
endmodule

// File: rtl/wdt_autostart.sv
module wdt_autostart
  import wdt_pkg::*;
#(
  parameter int MIN_EXP = 12
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ce_main,
  input  logic       ce_iosc,
  input  logic       ce_sub,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  output logic       rst_req,
  output logic       nmi_req
);
  wdt_cfg_t cfg;
  logic     cfg_fault;
  logic     wr_cfg;
  logic     wr_rst;
  logic     key_ok;
  logic     key_fault;
  logic     ovf;

  assign wr_cfg    = wr_en && !wr_sel;
  assign wr_rst    = wr_en && wr_sel;
  assign key_ok    = wr_rst && (wr_data == RESTART_KEY);
  assign key_fault = wr_rst && (wr_data != RESTART_KEY);

  wdt_cfg_reg u_cfg (
    .clk(clk), .rst(rst), .wr_cfg(wr_cfg), .wr_data(wr_data),
    .cfg(cfg), .cfg_fault(cfg_fault)
  );

  wdt_counter #(.MIN_EXP(MIN_EXP)) u_cnt (
    .clk(clk), .rst(rst), .ce_main(ce_main), .ce_iosc(ce_iosc),
    .ce_sub(ce_sub), .cfg(cfg), .restart(key_ok), .ovf(ovf)
  );

  wdt_req_gen u_req (
    .clk(clk), .rst(rst), .ovf(ovf), .nmi_mode(cfg.nmi_mode),
    .cfg_fault(cfg_fault), .key_fault(key_fault),
    .rst_req(rst_req), .nmi_req(nmi_req)
  );
endmodule

// File: tb/tb_wdt_autostart.sv
module tb_wdt_autostart;
  localparam int ME = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce_main = 1'b0, ce_iosc = 1'b0, ce_sub = 1'b0;
  logic wr_en = 1'b0, wr_sel = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic rst_req, nmi_req;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  wdt_autostart #(.MIN_EXP(ME)) dut (
    .clk(clk), .rst(rst), .ce_main(ce_main), .ce_iosc(ce_iosc),
    .ce_sub(ce_sub), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rst_req(rst_req), .nmi_req(nmi_req)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; ce_main = 0; ce_iosc = 0; ce_sub = 0; wr_en = 0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input bit sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Drive the selected enable with an irregular pattern, others held high.
  task automatic set_ce(input int src, input bit v);
    ce_main = 1'b1; ce_sub = 1'b1; ce_iosc = 1'b1;
    case (src)
      1: ce_main = v;
      2: ce_sub  = v;
      default: ce_iosc = v;
    endcase
  endtask

  task automatic idle_ce();
    ce_main = 0; ce_iosc = 0; ce_sub = 0;
  endtask

  // Count selected ticks until a request appears; check count and kind.
  task automatic run_ovf(input int src, input int limit, input bit nmi, input string tag);
    int ticks = 0;
    bit seen = 0;
    bit got_nmi = 0;
    bit both = 0;
    for (int i = 0; i < 6 * limit + 20; i++) begin
      @(negedge clk);
      if (rst_req || nmi_req) begin
        seen = 1; got_nmi = nmi_req; both = rst_req && nmi_req;
        break;
      end
      if ((i % 3) != 2) begin
        set_ce(src, 1'b1); ticks++;
      end else begin
        set_ce(src, 1'b0);
      end
    end
    idle_ce();
    chk(seen && ticks == limit, tag, ticks, limit);
    chk(got_nmi == nmi && !both, {tag, " R2 kind"}, int'(got_nmi), int'(nmi));
    @(negedge clk);
    chk(!rst_req && !nmi_req, {tag, " R2 single pulse"}, int'({rst_req, nmi_req}), 0);
  endtask

  initial begin
    do_reset();
    @(negedge clk);
    chk(!rst_req && !nmi_req, "reset state R2", int'({rst_req, nmi_req}), 0);

    // R1: default interval on the internal oscillator, no write
    run_ovf(0, 1 << (ME + 7), 1'b0, "R1 default");

    // R3 / R5: every threshold in both action modes
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 8; s++) begin
        do_reset();
        wr(1'b0, 8'(s | (m << 5)));
        run_ovf(0, 1 << (ME + s), m[0], m ? "R5 nmi sweep" : "R3 threshold sweep");
      end
    end
    // R5: after an interrupt the next interval is full length
    run_ovf(0, 1 << (ME + 7), 1'b1, "R5 restart after nmi");

    // R4: each source code, other enables held high
    for (int c = 0; c < 4; c++) begin
      do_reset();
      wr(1'b0, 8'(1 | (c << 3)));
      run_ovf((c == 3) ? 0 : c, 1 << (ME + 1), 1'b0, "R4 source");
    end

    // R6: second configuration write faults and is ignored
    do_reset();
    wr(1'b0, 8'h00);
    chk(!rst_req, "R6 first write clean", int'(rst_req), 0);
    wr(1'b0, 8'h27);
    chk(rst_req, "R6 second write faults", int'(rst_req), 1);
    @(negedge clk);
    chk(!rst_req, "R6 fault pulse single", int'(rst_req), 0);
    run_ovf(0, 1 << ME, 1'b0, "R6 config unchanged");

    // R7: key restarts a partly elapsed interval
    do_reset();
    wr(1'b0, 8'h00);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); ce_iosc = 1'b1;
    end
    @(negedge clk); idle_ce();
    wr(1'b1, 8'hAC);
    chk(!rst_req && !nmi_req, "R7 key no fault", int'(rst_req), 0);
    run_ovf(0, 1 << ME, 1'b0, "R7 full interval after key");

    // R8: wrong key faults
    wr(1'b1, 8'h55);
    chk(rst_req, "R8 bad key", int'(rst_req), 1);
    @(negedge clk);
    chk(!rst_req, "R8 pulse single", int'(rst_req), 0);

    // R9: halted counter never overflows, key does not revive it
    do_reset();
    wr(1'b0, 8'h40);
    begin
      int hits = 0;
      for (int i = 0; i < 200; i++) begin
        @(negedge clk);
        if (rst_req || nmi_req) hits++;
        ce_iosc = 1'b1;
        if (i == 100) begin
          wr_en = 1'b1; wr_sel = 1'b1; wr_data = 8'hAC;
        end else begin
          wr_en = 1'b0;
        end
      end
      idle_ce(); wr_en = 1'b0;
      chk(hits == 0, "R9 halted silent", hits, 0);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #3_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule